// File: doc/BRIEF.md
# Fixed-Point System Time Counter

This block keeps a free-running 64-bit time value that grows by a programmable fixed-point increment each time the timing oscillator ticks. The increment is chosen so that, for each link speed, a plain right shift of the time value by a known amount gives nanoseconds. Software reads the time as a low and a high 32-bit word, can overwrite either word (writing zero to both clears the count), and trims the frequency by rewriting the increment rather than touching the clock.

The link-speed presets load both the increment and the binary-point position (brought out as `ns_shift`). A trim request recomputes the increment from the preset of the selected speed, scaled by a signed parts-per-billion value. A build parameter selects a wide variant with a 31-bit increment field, or a narrow variant with a 24-bit field. In the narrow variant the presets and the binary point are both seven bits smaller, and an 8-bit increment-period field in bits 31:24 makes the counter add once every that many ticks.

Top module: `systime_counter`

## Requirements
- R1: After reset the time value is zero, the increment holds the 10 Gb/s preset (0x66666666 wide, 0xCCCCCC with period 1 narrow) and `ns_shift` is 28 (wide) or 21 (narrow).
- R2: On each effective tick the time value grows by the increment field; without a tick it holds its value.
- R3: The addition spans all 64 bits, so a carry out of the low word reaches the high word.
- R4: A read returns its data on `rd_data` in the cycle after `rd_en`. Address 0 returns the low word and captures the high word into a shadow; address 1 returns that shadow, so the pair is coherent even if the time carried in between.
- R5: A write to address 0 or 1 replaces that word of the time value; in a cycle with such a write the tick's addition is dropped; writing zero to both words clears the count.
- R6: A write to address 2 sets the increment; a tick in the same cycle still adds the old increment, and the new value applies from the next tick.
- R7: `preset_load` loads the preset for `speed_sel`: 0 or 3 (10 Gb/s or no link) gives 0x66666666 and shift 28, 1 (1 Gb/s) gives 0x40000000 and shift 24, 2 (100 Mb/s) gives 0x50000000 and shift 21; the narrow variant uses each value shifted right by 7 and each shift minus 7. Address 3 reads `ns_shift`.
- R8: `trim_req` sets the increment to base + base*ppb/10^9 (or base - base*|ppb|/10^9 for negative `trim_ppb`), where base is the preset of `speed_sel`, the quotient is truncated, and |ppb| is limited to 250,000,000.
- R9: The wide increment field is 31 bits: bit 31 of a write is discarded and reads back as 0.
- R10: In the narrow variant the time value grows only on every P-th tick counted from the last increment update, where P is bits 31:24 of the increment register (0 acts as 1); preset load and trim set P to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oscillator tick, one clock wide per tick |
| speed_sel | input | 2 | Link speed: 0 10 Gb/s, 1 1 Gb/s, 2 100 Mb/s, 3 no link |
| preset_load | input | 1 | Load increment and shift for `speed_sel` |
| trim_req | input | 1 | Recompute increment from `trim_ppb` |
| trim_ppb | input | 32 | Signed frequency trim in parts per billion |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low, 1 high, 2 increment |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address: 0 low, 1 high shadow, 2 increment, 3 shift |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| ns_shift | output | 6 | Binary-point position of the nanosecond count |
| time_now | output | 64 | Current time value |

## Verification
The counter is driven with runs of consecutive ticks from zero, with a low word set just below a carry, with ticks colliding with a time write and with an increment write, and with ticks spaced by an increment period of two in the narrow variant; these separate a plain add from a dropped add, a lost carry, and an early or late switch to a new increment. Reads split around a carry tell a coherent shadow from a live high word. Trims at positive, negative and over-limit ppb values at two speeds distinguish sign handling, truncation and clamping.

// File: rtl/systime_pkg.sv
package systime_pkg;

  typedef enum logic [1:0] {
    SPD_10G  = 2'd0,
    SPD_1G   = 2'd1,
    SPD_100M = 2'd2,
    SPD_NONE = 2'd3
  } speed_e;

  localparam logic [31:0] TRIM_LIMIT_PPB = 32'd250_000_000;
  localparam logic [63:0] PPB_SCALE      = 64'd1_000_000_000;
  localparam int          NARROW_DROP    = 7;

  // increment preset for a link speed, reduced for the narrow variant
  function automatic logic [31:0] preset_inc(input speed_e spd, input bit narrow);
    logic [31:0] v;
    case (spd)
      SPD_1G:   v = 32'h4000_0000;
      SPD_100M: v = 32'h5000_0000;
      default:  v = 32'h6666_6666;
    endcase
    return narrow ? (v >> NARROW_DROP) : v;
  endfunction

  // binary-point position matching preset_inc
  function automatic logic [5:0] preset_shift(input speed_e spd, input bit narrow);
    logic [5:0] s;
    case (spd)
      SPD_1G:   s = 6'd24;
      SPD_100M: s = 6'd21;
      default:  s = 6'd28;
    endcase
    return narrow ? (s - 6'(NARROW_DROP)) : s;
  endfunction

  // base +/- base*|ppb|/1e9 with |ppb| clamped
  function automatic logic [31:0] trim_inc(input logic [31:0] base,
                                           input logic signed [31:0] ppb);
    logic [31:0] mag;
    logic [63:0] prod;
    logic [31:0] diff;
    mag  = ppb[31] ? (32'd0 - 32'(ppb)) : 32'(ppb);
    if (mag > TRIM_LIMIT_PPB) mag = TRIM_LIMIT_PPB;
    prod = {32'd0, base} * {32'd0, mag};
    diff = 32'(prod / PPB_SCALE);
    return ppb[31] ? (base - diff) : (base + diff);
  endfunction

endpackage

// File: rtl/systime_incr_reg.sv
module systime_incr_reg
  import systime_pkg::*;
#(
  parameter bit NARROW  = 1'b0,
  parameter int FIELD_W = 31,
  parameter int PER_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  speed_sel,
  input  logic        preset_load,
  input  logic        trim_req,
  input  logic [31:0] trim_ppb,
  input  logic        wr_inc,
  input  logic [31:0] wr_data,
  output logic [31:0] inc_field,
  output logic [31:0] inc_rd,
  output logic [5:0]  ns_shift,
  output logic        add_fire
);

  speed_e              spd;
  logic [31:0]         base_inc;
  logic [31:0]         trimmed;
  logic [FIELD_W-1:0]  field_q;
  logic [5:0]          shift_q;
  logic                inc_update;

  assign spd        = speed_e'(speed_sel);
  assign base_inc   = preset_inc(spd, NARROW);
  assign trimmed    = trim_inc(base_inc, $signed(trim_ppb));
  assign inc_update = preset_load | trim_req | wr_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= FIELD_W'(preset_inc(SPD_10G, NARROW));
      shift_q <= preset_shift(SPD_10G, NARROW);
    end else if (preset_load) begin
      field_q <= base_inc[FIELD_W-1:0];
      shift_q <= preset_shift(spd, NARROW);
    end else if (trim_req) begin
      field_q <= trimmed[FIELD_W-1:0];
    end else if (wr_inc) begin
      field_q <= wr_data[FIELD_W-1:0];
    end
  end

  assign inc_field = 32'(field_q);
  assign ns_shift  = shift_q;

  generate
    if (NARROW) begin : g_period
      logic [PER_W-1:0] per_q;
      logic [PER_W-1:0] cnt_q;
      logic [PER_W-1:0] per_eff;

      assign per_eff  = (per_q == '0) ? PER_W'(1) : per_q;
      assign add_fire = tick && (cnt_q == per_eff - PER_W'(1));
      assign inc_rd   = {per_q, field_q};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          per_q <= PER_W'(1);
          cnt_q <= '0;
        end else begin
          if (preset_load || trim_req) per_q <= PER_W'(1);
          else if (wr_inc)             per_q <= wr_data[FIELD_W +: PER_W];
          if (inc_update || add_fire)  cnt_q <= '0;
          else if (tick)               cnt_q <= cnt_q + PER_W'(1);
        end
      end
    end else begin : g_plain
      assign add_fire = tick;
      assign inc_rd   = 32'(field_q);
    end
  endgenerate

endmodule

// File: rtl/systime_accum.sv
module systime_accum #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [31:0]       wr_data,
  input  logic              add_fire,
  input  logic [31:0]       inc_field,
  output logic [TIME_W-1:0] time_q,
  output logic              time_wr
);

  localparam int HALF = TIME_W / 2;

  assign time_wr = wr_lo | wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (time_wr) begin
      if (wr_lo) time_q[HALF-1:0]      <= HALF'(wr_data);
      if (wr_hi) time_q[TIME_W-1:HALF] <= HALF'(wr_data);
    end else if (add_fire) begin
      time_q <= time_q + TIME_W'(inc_field);
    end
  end

endmodule

// File: rtl/systime_read_port.sv
module systime_read_port #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  input  logic [TIME_W-1:0] time_q,
  input  logic [31:0]       inc_rd,
  input  logic [5:0]        ns_shift,
  output logic [31:0]       rd_data,
  output logic [31:0]       shadow_hi,
  output logic              lo_snap
);

  localparam int HALF = TIME_W / 2;

  assign lo_snap = rd_en && (rd_addr == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      shadow_hi <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        2'd0: begin
          rd_data   <= 32'(time_q[HALF-1:0]);
          shadow_hi <= 32'(time_q[TIME_W-1:HALF]);
        end
        2'd1:    rd_data <= shadow_hi;
        2'd2:    rd_data <= inc_rd;
        default: rd_data <= 32'(ns_shift);
      endcase
    end
  end

endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import systime_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  speed_sel,
  input  logic        preset_load,
  input  logic        trim_req,
  input  logic [31:0] trim_ppb,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [5:0]  ns_shift,
  output logic [63:0] time_now
);

  localparam int TIME_W  = 64;
  localparam int FIELD_W = NARROW ? 24 : 31;
  localparam int PER_W   = 32 - FIELD_W;

  logic        wr_lo, wr_hi, wr_inc;
  logic [31:0] inc_field, inc_rd, shadow_hi;
  logic        add_fire, time_wr, lo_snap;

  assign wr_lo  = wr_en && (wr_addr == 2'd0);
  assign wr_hi  = wr_en && (wr_addr == 2'd1);
  assign wr_inc = wr_en && (wr_addr == 2'd2);

  systime_incr_reg #(.NARROW(NARROW), .FIELD_W(FIELD_W), .PER_W(PER_W)) u_inc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .speed_sel(speed_sel),
    .preset_load(preset_load), .trim_req(trim_req), .trim_ppb(trim_ppb),
    .wr_inc(wr_inc), .wr_data(wr_data), .inc_field(inc_field),
    .inc_rd(inc_rd), .ns_shift(ns_shift), .add_fire(add_fire)
  );

  systime_accum #(.TIME_W(TIME_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .add_fire(add_fire), .inc_field(inc_field),
    .time_q(time_now), .time_wr(time_wr)
  );

  systime_read_port #(.TIME_W(TIME_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .time_q(time_now), .inc_rd(inc_rd), .ns_shift(ns_shift),
    .rd_data(rd_data), .shadow_hi(shadow_hi), .lo_snap(lo_snap)
  );

endmodule

// File: rtl/systime_counter_chk.sv
module systime_counter_chk
  import systime_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        add_fire,
  input logic        time_wr,
  input logic        lo_snap,
  input logic        rd_en,
  input logic [1:0]  rd_addr,
  input logic [31:0] rd_data,
  input logic [31:0] shadow_hi,
  input logic [31:0] inc_field,
  input logic [5:0]  ns_shift,
  input logic [63:0] time_now,
  input logic        trim_req,
  input logic        preset_load,
  input logic [31:0] trim_ppb,
  input logic [1:0]  speed_sel
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_fire && !time_wr) |=> $stable(time_now));

  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (add_fire && !time_wr) |=> time_now == $past(time_now) + 64'($past(inc_field)));

  assert_snap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_snap |=> (shadow_hi == $past(time_now[63:32]) && rd_data == $past(time_now[31:0])));

  assert_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd1) |=> rd_data == $past(shadow_hi));

  assert_trim_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_req && !preset_load && !trim_ppb[31]) |=>
      inc_field >= preset_inc(speed_e'($past(speed_sel)), NARROW));

  assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> ns_shift == preset_shift(speed_e'($past(speed_sel)), NARROW));

endmodule

bind systime_counter systime_counter_chk #(.NARROW(NARROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .add_fire(add_fire), .time_wr(time_wr),
  .lo_snap(lo_snap), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .shadow_hi(shadow_hi), .inc_field(inc_field), .ns_shift(ns_shift),
  .time_now(time_now), .trim_req(trim_req), .preset_load(preset_load),
  .trim_ppb(trim_ppb), .speed_sel(speed_sel)
);

// File: tb/sim_systime_counter.sv
module sim_systime_counter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // shared controls
  logic [1:0]  speed_sel = 2'd0;
  logic        preset_load = 1'b0, trim_req = 1'b0;
  logic [31:0] trim_ppb = '0;
  // wide instance
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [5:0]  ns_shift;
  logic [63:0] time_now;
  // narrow instance
  logic        n_tick = 1'b0, n_wr_en = 1'b0, n_rd_en = 1'b0;
  logic [1:0]  n_wr_addr = '0, n_rd_addr = '0;
  logic [31:0] n_wr_data = '0, n_rd_data;
  logic [5:0]  n_shift;
  logic [63:0] n_time;

  int total = 0, fails = 0;
  bit done = 1'b0;

  systime_counter #(.NARROW(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .speed_sel(speed_sel),
    .preset_load(preset_load), .trim_req(trim_req), .trim_ppb(trim_ppb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .ns_shift(ns_shift), .time_now(time_now)
  );

  systime_counter #(.NARROW(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .tick(n_tick), .speed_sel(2'd0),
    .preset_load(1'b0), .trim_req(1'b0), .trim_ppb(32'd0),
    .wr_en(n_wr_en), .wr_addr(n_wr_addr), .wr_data(n_wr_data), .rd_en(n_rd_en),
    .rd_addr(n_rd_addr), .rd_data(n_rd_data), .ns_shift(n_shift), .time_now(n_time)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // expected trim, computed with 64-bit integers
  function automatic longint unsigned exp_trim(input longint unsigned base, input longint ppb);
    longint m = (ppb < 0) ? -ppb : ppb;
    longint unsigned d;
    if (m > 250000000) m = 250000000;
    d = (base * longint'(m)) / 1000000000;
    return (ppb < 0) ? base - d : base + d;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 time", time_now, 0);
    check("R1 shift", ns_shift, 28);
    rd(2'd2, d); check("R1 inc", d, 32'h6666_6666);
    check("R1 narrow shift", n_shift, 21);
    n_rd_en = 1'b1; n_rd_addr = 2'd2; @(negedge clk); n_rd_en = 1'b0;
    check("R1 narrow inc", n_rd_data, 32'h01CC_CCCC);
  endtask

  task automatic t_count();
    ticks(3);
    check("R2 three ticks", time_now, 64'h1_3333_3332);
    @(negedge clk); @(negedge clk);
    check("R2 hold", time_now, 64'h1_3333_3332);
  endtask

  task automatic t_carry();
    wr(2'd0, 32'hFFFF_FFF0); wr(2'd1, 32'd5);
    ticks(1);
    check("R3 carry", time_now, 64'h6_6666_6656);
  endtask

  task automatic t_read();
    logic [31:0] lo, hi;
    wr(2'd0, 32'hFFFF_FFF0); wr(2'd1, 32'd7);
    rd(2'd0, lo);
    ticks(1);
    rd(2'd1, hi);
    check("R4 low word", lo, 32'hFFFF_FFF0);
    check("R4 shadow high", hi, 32'd7);
    rd(2'd0, lo); rd(2'd1, hi);
    check("R4 fresh high", hi, 32'd8);
    check("R4 fresh low", lo, 32'h6666_6656);
  endtask

  task automatic t_write();
    wr(2'd0, 0); wr(2'd1, 0);
    check("R5 clear", time_now, 0);
    ticks(1);
    tick = 1'b1; wr(2'd0, 32'h1234); tick = 1'b0;
    check("R5 write wins", time_now, 64'h1234);
  endtask

  task automatic t_incwr();
    wr(2'd0, 0); wr(2'd1, 0);
    tick = 1'b1; wr(2'd2, 32'h10);
    check("R6 old inc same cycle", time_now, 64'h6666_6666);
    @(negedge clk); tick = 1'b0;
    check("R6 new inc next tick", time_now, 64'h6666_6676);
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d);
    check("R9 bit31 dropped", d, 32'h7FFF_FFFF);
  endtask

  task automatic t_preset(input logic [1:0] s, input logic [31:0] ei, input int es);
    logic [31:0] d;
    speed_sel = s; preset_load = 1'b1; @(negedge clk); preset_load = 1'b0;
    rd(2'd2, d);
    check("R7 preset inc", d, ei);
    check("R7 preset shift", ns_shift, es);
    rd(2'd3, d);
    check("R7 shift readback", d, es);
  endtask

  task automatic t_trim(input logic [1:0] s, input longint base, input longint ppb);
    logic [31:0] d;
    speed_sel = s; trim_ppb = 32'(ppb); trim_req = 1'b1;
    @(negedge clk); trim_req = 1'b0;
    rd(2'd2, d);
    check("R8 trim", d, exp_trim(base, ppb));
  endtask

  task automatic t_period();
    n_wr_en = 1'b1; n_wr_addr = 2'd2; n_wr_data = {8'd2, 24'h000100};
    @(negedge clk); n_wr_en = 1'b0;
    n_tick = 1'b1; @(negedge clk); n_tick = 1'b0;
    check("R10 first tick skipped", n_time, 0);
    n_tick = 1'b1; repeat (3) @(negedge clk); n_tick = 1'b0;
    check("R10 every second tick", n_time, 64'h200);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_carry();
    t_read();
    t_write();
    t_incwr();
    t_width();
    t_preset(2'd1, 32'h4000_0000, 24);
    t_preset(2'd2, 32'h5000_0000, 21);
    t_preset(2'd3, 32'h6666_6666, 28);
    t_trim(2'd0, 64'h6666_6666, 1000000);
    t_trim(2'd0, 64'h6666_6666, -300000000);
    t_trim(2'd0, 64'h6666_6666, 250000000);
    t_trim(2'd1, 64'h4000_0000, -1000);
    t_period();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule